// File: doc/BRIEF.md
# Segment Limit Guard

This block screens one memory access per cycle against the descriptor of the segment it uses, before any address translation happens. Each access brings its address (segment base already added), its size in bytes, whether it writes or fetches, and the segment's base, limit and attribute bits. The block decides whether the access breaks the segment's rights or bounds and raises a protection fault with a zero fault code if it does. When the processor runs in 64-bit mode all checks are skipped.

Both segment directions are handled. An expand-up segment allows addresses up to its limit. An expand-down segment reserves its low region up to the limit. For both directions a limit that is numerically below the base is treated as its own case. The end of an access is computed one bit wider than the address, so an access that runs past the top of the address space is never mistaken for a small one. One register stage carries the verdict and the unchanged address to the output, together with a valid flag.

Top module: `seg_guard`

## Requirements
- R1: When `efer_lma` and `cs_long_mode` are both 1 the access never faults, whatever its rights and bounds. If only one of them is 1, all checks apply.
- R2: A write (`is_write`=1) to a segment whose `seg_writable` is 0 faults.
- R3: An access with `is_write`=0 and `is_exec`=0 to a segment whose `seg_readable` is 0 faults. An execute access or a write does not fault for lack of the readable bit.
- R4: Expand-up (`seg_expand_down`=0) with limit >= base: the access faults exactly when limit < address + size.
- R5: Expand-up with limit < base: the access faults exactly when limit < address + size and address < base.
- R6: Expand-down (`seg_expand_down`=1) with limit >= base: the access faults exactly when address <= limit and address + size >= base.
- R7: Expand-down with limit < base: the access faults exactly when address <= limit or address + size >= base.
- R8: address + size is formed with ADDR_W+1 bits, so a sum past 2^ADDR_W compares as larger than any limit.
- R9: `out_code` is 0 on every valid output, faulting or not.
- R10: `out_valid` follows `in_valid` one clock later. `out_fault` and `out_addr` on that cycle belong to the access presented one clock earlier, and `out_addr` equals that access's `in_addr` unchanged.
- R11: During and right after reset `out_valid` and `out_fault` are 0.
- R12: In a cycle where `out_valid` is 0, `out_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An access is presented this cycle |
| in_addr | input | ADDR_W | Access address with segment base applied |
| in_size | input | SIZE_W | Access size in bytes |
| is_write | input | 1 | Access writes |
| is_exec | input | 1 | Access is an instruction fetch |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| seg_readable | input | 1 | Segment may be read as data |
| seg_writable | input | 1 | Segment may be written |
| seg_expand_down | input | 1 | Segment grows downward |
| efer_lma | input | 1 | Long mode active |
| cs_long_mode | input | 1 | Code segment is a 64-bit segment |
| out_valid | output | 1 | A verdict is present |
| out_fault | output | 1 | Protection fault on the reported access |
| out_code | output | CODE_W | Fault code, always 0 |
| out_addr | output | ADDR_W | Address of the reported access, unchanged |

## Verification
The assertions check every cycle that the rights faults, the 64-bit-mode bypass, the bound-violation signal and the valid, address and idle behaviour of the output stage appear one clock after the access. Whether the bound comparison itself picks the right rule for each direction, handles a limit below the base and uses the wide end-of-access sum is shown only by the bench. Its scenarios place accesses just inside and just outside each boundary, including one that crosses the top of the address space.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  // attribute bits of the segment being accessed
  typedef struct packed {
    logic readable;
    logic writable;
    logic expand_down;
  } seg_attr_t;

  // which bound rule applies to an access
  typedef enum logic [1:0] {
    RULE_UP_PLAIN   = 2'b00,
    RULE_UP_WRAP    = 2'b01,
    RULE_DOWN_PLAIN = 2'b10,
    RULE_DOWN_WRAP  = 2'b11
  } bound_rule_e;

endpackage

// File: rtl/seg_access_rights.sv
module seg_access_rights
  import seg_guard_pkg::*;
(
  input  seg_attr_t attr,
  input  logic      is_write,
  input  logic      is_exec,
  output logic      write_denied,
  output logic      read_denied,
  output logic      rights_fault
);

  function automatic logic data_read(input logic wr, input logic ex);
    return !wr && !ex;
  endfunction

  assign write_denied = is_write && !attr.writable;
  assign read_denied  = data_read(is_write, is_exec) && !attr.readable;
  assign rights_fault = write_denied || read_denied;

endmodule

// File: rtl/seg_bound_chk.sv
module seg_bound_chk
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              expand_down,
  output bound_rule_e       rule,
  output logic              bound_fault
);

  localparam int END_W = ADDR_W + 1;

  // end of the access, one bit wider than the address
  function automatic logic [END_W-1:0] access_end(input logic [ADDR_W-1:0] a,
                                                  input logic [SIZE_W-1:0] s);
    return {1'b0, a} + END_W'(s);
  endfunction

  function automatic logic [END_W-1:0] widen(input logic [ADDR_W-1:0] v);
    return {1'b0, v};
  endfunction

  logic [END_W-1:0] end_x;
  logic             lim_below_base;
  logic             end_past_limit;
  logic             addr_below_base;
  logic             addr_in_low;
  logic             end_reaches_base;

  assign end_x            = access_end(addr, size);
  assign lim_below_base   = limit < base;
  assign end_past_limit   = widen(limit) < end_x;
  assign addr_below_base  = addr < base;
  assign addr_in_low      = addr <= limit;
  assign end_reaches_base = end_x >= widen(base);

  assign rule = bound_rule_e'({expand_down, lim_below_base});

  always_comb begin
    unique case (rule)
      RULE_UP_PLAIN:   bound_fault = end_past_limit;
      RULE_UP_WRAP:    bound_fault = end_past_limit && addr_below_base;
      RULE_DOWN_PLAIN: bound_fault = addr_in_low && end_reaches_base;
      RULE_DOWN_WRAP:  bound_fault = addr_in_low || end_reaches_base;
      default:         bound_fault = 1'b0;
    endcase
  end

endmodule

// File: rtl/seg_result_stage.sv
module seg_result_stage #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              fault,
  input  logic [ADDR_W-1:0] addr,
  output logic              out_valid,
  output logic              out_fault,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_code  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid && fault;
      out_code  <= '0;
      if (in_valid) out_addr <= addr;
    end
  end

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              is_write,
  input  logic              is_exec,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              seg_readable,
  input  logic              seg_writable,
  input  logic              seg_expand_down,
  input  logic              efer_lma,
  input  logic              cs_long_mode,
  output logic              out_valid,
  output logic              out_fault,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_addr
);

  seg_attr_t   attr;
  bound_rule_e rule_w;
  logic        checks_on;
  logic        write_denied_w;
  logic        read_denied_w;
  logic        rights_fault_w;
  logic        bound_fault_w;
  logic        fault_now;

  assign attr      = '{readable: seg_readable, writable: seg_writable,
                       expand_down: seg_expand_down};
  assign checks_on = !(efer_lma && cs_long_mode);

  seg_access_rights u_rights (
    .attr         (attr),
    .is_write     (is_write),
    .is_exec      (is_exec),
    .write_denied (write_denied_w),
    .read_denied  (read_denied_w),
    .rights_fault (rights_fault_w)
  );

  seg_bound_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bound (
    .addr        (in_addr),
    .size        (in_size),
    .base        (seg_base),
    .limit       (seg_limit),
    .expand_down (seg_expand_down),
    .rule        (rule_w),
    .bound_fault (bound_fault_w)
  );

  assign fault_now = checks_on && (rights_fault_w || bound_fault_w);

  seg_result_stage #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fault     (fault_now),
    .addr      (in_addr),
    .out_valid (out_valid),
    .out_fault (out_fault),
    .out_code  (out_code),
    .out_addr  (out_addr)
  );

endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              is_write,
  input logic              is_exec,
  input logic              seg_readable,
  input logic              seg_writable,
  input logic              efer_lma,
  input logic              cs_long_mode,
  input logic              bound_hit,
  input logic              out_valid,
  input logic              out_fault,
  input logic [ADDR_W-1:0] out_addr
);

  logic legacy;
  assign legacy = !(efer_lma && cs_long_mode);

  // R1
  bypass_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && efer_lma && cs_long_mode) |=> !out_fault);

  // R2
  write_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy && is_write && !seg_writable) |=> out_fault);

  // R3
  read_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy && !is_write && !is_exec && !seg_readable) |=> out_fault);

  // R4
  bound_to_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy && bound_hit) |=> out_fault);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  addr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_addr == $past(in_addr)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_fault);

endmodule

bind seg_guard seg_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_addr      (in_addr),
  .is_write     (is_write),
  .is_exec      (is_exec),
  .seg_readable (seg_readable),
  .seg_writable (seg_writable),
  .efer_lma     (efer_lma),
  .cs_long_mode (cs_long_mode),
  .bound_hit    (bound_fault_w),
  .out_valid    (out_valid),
  .out_fault    (out_fault),
  .out_addr     (out_addr)
);

// File: tb/sim_seg_guard.sv
`timescale 1ns/1ps
module sim_seg_guard;

  localparam int AW = 32;
  localparam int SW = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [SW-1:0] in_size = '0;
  logic          is_write = 1'b0, is_exec = 1'b0;
  logic [AW-1:0] seg_base = '0, seg_limit = '0;
  logic          seg_readable = 1'b0, seg_writable = 1'b0, seg_expand_down = 1'b0;
  logic          efer_lma = 1'b0, cs_long_mode = 1'b0;
  logic          out_valid, out_fault;
  logic [CW-1:0] out_code;
  logic [AW-1:0] out_addr;

  always #2.5 clk = ~clk;

  seg_guard #(.ADDR_W(AW), .SIZE_W(SW), .CODE_W(CW)) u0 (.*);

  typedef struct {
    logic          fault;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  task automatic check(input bit ok, input string tag, input string detail);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  // expected verdict, stated as "does the access fit"
  function automatic bit model(bit lma, bit csl, bit wr, bit ex, bit rd, bit wa,
                               bit dn, longint a, longint sz, longint b, longint l);
    longint last_excl;
    bit fits;
    if (lma && csl) return 0;
    if (wr && !wa) return 1;
    if (!wr && !ex && !rd) return 1;
    last_excl = a + sz;
    if (!dn) begin
      if (l >= b) fits = (last_excl <= l);
      else        fits = (last_excl <= l) || (a >= b);
    end else begin
      if (l >= b) fits = (a > l) || (last_excl < b);
      else        fits = (a > l) && (last_excl < b);
    end
    return !fits;
  endfunction

  task automatic send(input string tag, input bit lma, input bit csl, input bit wr,
                      input bit ex, input bit rd, input bit wa, input bit dn,
                      input longint a, input longint sz, input longint b, input longint l);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_addr = AW'(a); in_size = SW'(sz);
    is_write = wr; is_exec = ex; seg_readable = rd; seg_writable = wa;
    seg_expand_down = dn; seg_base = AW'(b); seg_limit = AW'(l);
    efer_lma = lma; cs_long_mode = csl;
    e.fault = model(lma, csl, wr, ex, rd, wa, dn, a, sz, b, l);
    e.addr  = AW'(a);
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_addr  = 32'hDEAD_0000 + AW'(i);
      is_write = 1'b1; seg_writable = 1'b0;
    end
  endtask

  // monitor: scoreboard compare after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", "output without a pending access");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_fault == e.fault, e.tag,
                $sformatf("fault=%0b expected %0b", out_fault, e.fault));
          check(out_addr == e.addr, {e.tag, " R10"},
                $sformatf("addr=%h expected %h", out_addr, e.addr));
          check(out_code == '0, "R9",
                $sformatf("code=%h expected 0", out_code));
        end
      end else begin
        check(out_fault == 1'b0, "R12",
              $sformatf("fault=%0b expected 0 while idle", out_fault));
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_fault == 0, "R11",
          $sformatf("valid=%0b fault=%0b expected 0 0", out_valid, out_fault));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_fault == 0, "R11",
          $sformatf("after reset valid=%0b fault=%0b expected 0 0", out_valid, out_fault));

    // R1: 64-bit mode bypasses a write to a read-only, out-of-bounds segment
    send("R1", 1,1, 1,0, 1,0, 0, 64'h5000, 4, 0, 64'h100);
    send("R1", 1,0, 1,0, 1,0, 0, 64'h10,   4, 0, 64'h100);
    send("R1", 0,1, 1,0, 1,0, 0, 64'h10,   4, 0, 64'h100);
    // R2: write protection
    send("R2", 0,0, 1,0, 1,0, 0, 64'h10, 4, 0, 64'hFFFF);
    send("R2", 0,0, 1,0, 1,1, 0, 64'h10, 4, 0, 64'hFFFF);
    send("R2", 0,0, 0,1, 1,0, 0, 64'h10, 4, 0, 64'hFFFF);
    // R3: read protection
    send("R3", 0,0, 0,0, 0,1, 0, 64'h10, 4, 0, 64'hFFFF);
    send("R3", 0,0, 0,1, 0,1, 0, 64'h10, 4, 0, 64'hFFFF);
    send("R3", 0,0, 1,0, 0,1, 0, 64'h10, 4, 0, 64'hFFFF);
    idle(2);
    // R4: expand-up, limit >= base
    send("R4", 0,0, 0,0, 1,1, 0, 64'hFFC, 4, 0, 64'h1000);
    send("R4", 0,0, 0,0, 1,1, 0, 64'hFFD, 4, 0, 64'h1000);
    send("R4", 0,0, 0,0, 1,1, 0, 64'h1000, 0, 0, 64'h1000);
    // R5: expand-up, limit < base
    send("R5", 0,0, 0,0, 1,1, 0, 64'hFFD,  4, 64'h8000, 64'h1000);
    send("R5", 0,0, 0,0, 1,1, 0, 64'h9000, 4, 64'h8000, 64'h1000);
    send("R5", 0,0, 0,0, 1,1, 0, 64'h0FF0, 4, 64'h8000, 64'h1000);
    // R6: expand-down, limit >= base
    send("R6", 0,0, 0,0, 1,1, 1, 64'h1500, 4, 64'h1000, 64'h2000);
    send("R6", 0,0, 0,0, 1,1, 1, 64'h2001, 4, 64'h1000, 64'h2000);
    send("R6", 0,0, 0,0, 1,1, 1, 64'h0F00, 4, 64'h1000, 64'h2000);
    // R7: expand-down, limit < base
    send("R7", 0,0, 0,0, 1,1, 1, 64'h0800, 4, 64'h8000, 64'h1000);
    send("R7", 0,0, 0,0, 1,1, 1, 64'h4000, 4, 64'h8000, 64'h1000);
    send("R7", 0,0, 0,0, 1,1, 1, 64'h7FFE, 2, 64'h8000, 64'h1000);
    send("R7", 0,0, 0,0, 1,1, 1, 64'h1001, 2, 64'h8000, 64'h1000);
    idle(1);
    // R8: sum beyond the top of the address space
    send("R8", 0,0, 0,0, 1,1, 0, 64'hFFFF_FFFE, 4, 0, 64'hFFFF_FFFF);
    send("R8", 0,0, 0,0, 1,1, 0, 64'hFFFF_FFFB, 4, 0, 64'hFFFF_FFFF);
    send("R8", 0,0, 0,0, 1,1, 1, 64'hFFFF_FFFE, 4, 64'hFFFF_FFF0, 64'h10);
    idle(3);
    // R10: back-to-back stream with varying addresses
    for (int k = 0; k < 6; k++)
      send("R10", 0,0, k[0],0, 1,1, 0, 64'h100 + 64'(k) * 64'h7F0, 8, 0, 64'h1800);
    idle(4);

    check(exp_q.size() == 0, "R10",
          $sformatf("pending=%0d expected 0", exp_q.size()));
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule